// File: doc/BRIEF.md
# I2C Master Bus-Clock Phase Sequencer

This block sets the timing of the bus clock (SCL) and of the SDA edges for an I2C master. The byte engine gives it one command at a time: a START, a single data bit, a repeated START, or a STOP. The block then drives both open-drain lines through active-high "pull low" outputs. It also tells the byte engine when SDA has been updated and when the receiving side should sample SDA. Byte framing, FIFOs and register decode sit outside the block.

Four counts, all in system clock cycles, set the timing. They are held steady by the register file while the block runs. The first is the full bit period, which is the input clock rate divided by the bus rate. The second is the SCL low time, usually half the period. The third is the setup time from SCL rising to the SDA edge of a repeated START or STOP, also usually half the period. The fourth is the delay from SCL falling to the SDA update, usually a sixteenth of the period. With a 100 MHz system clock, a period count of 1000 gives 100 kHz and a count of 250 gives 400 kHz.

The block reads back the SCL line. The high phase is timed from the first cycle in which SCL is seen high, so a target that holds SCL low stretches the bit.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset both line drives are released (`scl_drive_low`=0, `sda_drive_low`=0), `cmd_ready` is 1, and `sda_update_stb`, `sda_sample_stb`, `stretch_seen` and `done_stb` are 0.
- R2: Command codes are 0 START, 1 BIT, 2 RESTART and 3 STOP. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1, and cycle 0 is the cycle after that edge. A START pulls SDA low in cycle 0 and pulls SCL low in cycle max(SETUP,1).
- R3: For BIT, RESTART and STOP, SCL stays low and is released in cycle max(LOW,1), written L below.
- R4: `sda_update_stb` is high in exactly one cycle, cycle min(DSETUP, L-1). From the next cycle `sda_drive_low` takes the new value: for BIT it is the inverse of `cmd_bit`, for RESTART it is 0 (released), and for STOP it is 1.
- R5: For BIT, SCL is pulled low again H = max(PERIOD-L, 2) cycles after the first cycle in which `scl_in` reads high. With no stretching the bit lasts max(PERIOD, L+2) cycles.
- R6: For BIT, `sda_sample_stb` is high in exactly one cycle, floor(H/2) cycles after the first cycle in which `scl_in` reads high.
- R7: If SCL is released but `scl_in` stays low for K cycles, `stretch_seen` is high in exactly those K cycles, and every later timing point moves by K cycles.
- R8: For STOP, SDA is released max(SETUP,2) cycles after the first cycle with `scl_in` high. SCL stays released.
- R9: For RESTART, SDA is pulled low max(SETUP,2) cycles after the first cycle with `scl_in` high, and SCL is pulled low max(SETUP,1) cycles after that.
- R10: `done_stb` pulses for one cycle, in the cycle of the final line change of the command, and `cmd_ready` is 1 in that cycle. `cmd_valid` has no effect while `cmd_ready` is 0. At most one of the three strobes is high in any cycle.
- R11: While SCL is released, SDA changes only as the START edge, the RESTART edge or the STOP edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period | input | CW | Full bit period in clock cycles |
| cfg_low | input | CW | SCL low time in clock cycles |
| cfg_setup | input | CW | Setup time from SCL rising to the RESTART/STOP edge on SDA |
| cfg_dsetup | input | CW | Delay from the start of the low phase to the SDA update |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 START, 1 BIT, 2 RESTART, 3 STOP |
| cmd_bit | input | 1 | Bit value for a BIT command |
| cmd_ready | output | 1 | Idle and able to accept a command |
| scl_in | input | 1 | Readback of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| sda_update_stb | output | 1 | SDA updated this cycle (low phase) |
| sda_sample_stb | output | 1 | Sample SDA now (middle of the high phase) |
| stretch_seen | output | 1 | SCL released but held low by another device |
| done_stb | output | 1 | Command finished |

## Verification
The in-design assertions check properties that must hold on every cycle. The strobes never overlap. The phase counter never passes its limit. SCL falls only at the end of a high or hold phase, and rises only at the end of a low phase. `stretch_seen` is never set while SCL is driven low. SDA never moves under a released SCL except at a START, RESTART or STOP edge. The exact cycle of each edge and strobe depends on the four counts after clamping, and on how long the line is stretched. Only the bench's sweep over small counts, a stretched bit, an ignored command and full-rate settings can show those timings.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    localparam int DEF_CNT_W = 12;

    typedef enum logic [1:0] {
        OP_START   = 2'd0,
        OP_BIT     = 2'd1,
        OP_RESTART = 2'd2,
        OP_STOP    = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOW,
        PH_WAIT_HI,
        PH_HIGH,
        PH_SETUP,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        bus_op_e op;
        logic    bit_val;
    } bus_cmd_t;

    function automatic int unsigned at_least(input int unsigned v, input int unsigned lo);
        return (v < lo) ? lo : v;
    endfunction

    // cycles SCL is held low
    function automatic int unsigned low_len(input int unsigned low);
        return at_least(low, 1);
    endfunction

    // cycles SCL is high, counted from the first high readback
    function automatic int unsigned high_len(input int unsigned period, input int unsigned low);
        int unsigned lo;
        lo = low_len(low);
        return at_least((period > lo) ? period - lo : 0, 2);
    endfunction

    function automatic int unsigned dset_pos(input int unsigned dset, input int unsigned low);
        int unsigned lo;
        lo = low_len(low);
        return (dset >= lo) ? lo - 1 : dset;
    endfunction

endpackage

// File: rtl/scl_limits.sv
module scl_limits
    import scl_timing_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_dsetup,
    output logic [CW-1:0] lim_low,
    output logic [CW-1:0] lim_high,
    output logic [CW-1:0] pos_dset,
    output logic [CW-1:0] lim_su_rise,
    output logic [CW-1:0] lim_su_hold,
    output logic [CW-1:0] pos_smp
);
    int unsigned p_u, l_u, s_u, d_u, hi_u;

    always_comb begin
        p_u  = 32'(cfg_period);
        l_u  = 32'(cfg_low);
        s_u  = 32'(cfg_setup);
        d_u  = 32'(cfg_dsetup);
        hi_u = high_len(p_u, l_u);
        lim_low     = CW'(low_len(l_u));
        // first high cycle is spent in the wait state
        lim_high    = CW'(hi_u - 1);
        pos_dset    = CW'(dset_pos(d_u, l_u));
        lim_su_rise = CW'(at_least(s_u, 2) - 1);
        lim_su_hold = CW'(at_least(s_u, 1));
        pos_smp     = CW'(hi_u / 2 - 1);
    end
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [CW-1:0] lim,
    output logic [CW-1:0] cnt,
    output logic          last
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    assign last = (cnt >= lim - 1'b1);
endmodule

// File: rtl/scl_seq_fsm.sv
module scl_seq_fsm
    import scl_timing_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic          cmd_bit,
    input  logic          scl_in,
    input  logic [CW-1:0] lim_low,
    input  logic [CW-1:0] lim_high,
    input  logic [CW-1:0] pos_dset,
    input  logic [CW-1:0] lim_su_rise,
    input  logic [CW-1:0] lim_su_hold,
    input  logic [CW-1:0] pos_smp,
    input  logic [CW-1:0] cnt,
    input  logic          last,
    output logic [CW-1:0] lim,
    output logic          cnt_clr,
    output logic          cmd_ready,
    output logic          scl_low,
    output logic          sda_low,
    output logic          upd_stb,
    output logic          smp_stb,
    output logic          stretch,
    output logic          done
);
    phase_e   st, st_n;
    bus_cmd_t cur;

    always_comb begin
        unique case (st)
            PH_LOW:   lim = lim_low;
            PH_HIGH:  lim = lim_high;
            PH_SETUP: lim = lim_su_rise;
            PH_HOLD:  lim = lim_su_hold;
            default:  lim = {{(CW-1){1'b0}}, 1'b1};
        endcase
    end

    assign cmd_ready = (st == PH_IDLE);
    assign upd_stb   = (st == PH_LOW)  && (cnt == pos_dset);
    assign smp_stb   = (st == PH_HIGH) && (cnt == pos_smp);
    assign stretch   = (st == PH_WAIT_HI) && !scl_in;

    always_comb begin
        st_n = st;
        unique case (st)
            PH_IDLE:
                if (cmd_valid)
                    st_n = (bus_op_e'(cmd_op) == OP_START) ? PH_HOLD : PH_LOW;
            PH_LOW:
                if (last) st_n = PH_WAIT_HI;
            PH_WAIT_HI:
                if (scl_in) st_n = (cur.op == OP_BIT) ? PH_HIGH : PH_SETUP;
            PH_HIGH:
                if (last) st_n = PH_IDLE;
            PH_SETUP:
                if (last) st_n = (cur.op == OP_STOP) ? PH_IDLE : PH_HOLD;
            PH_HOLD:
                if (last) st_n = PH_IDLE;
            default:
                st_n = PH_IDLE;
        endcase
    end

    assign cnt_clr = (st_n != st) || (st == PH_IDLE) || (st == PH_WAIT_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= PH_IDLE;
            cur     <= '{op: OP_START, bit_val: 1'b0};
            scl_low <= 1'b0;
            sda_low <= 1'b0;
            done    <= 1'b0;
        end else begin
            st   <= st_n;
            done <= 1'b0;
            unique case (st)
                PH_IDLE:
                    if (cmd_valid) begin
                        cur <= '{op: bus_op_e'(cmd_op), bit_val: cmd_bit};
                        if (bus_op_e'(cmd_op) == OP_START) sda_low <= 1'b1;
                    end
                PH_LOW: begin
                    if (upd_stb)
                        sda_low <= (cur.op == OP_BIT) ? !cur.bit_val : (cur.op == OP_STOP);
                    if (last) scl_low <= 1'b0;
                end
                PH_HIGH:
                    if (last) begin
                        scl_low <= 1'b1;
                        done    <= 1'b1;
                    end
                PH_SETUP:
                    if (last) begin
                        if (cur.op == OP_STOP) begin
                            sda_low <= 1'b0;
                            done    <= 1'b1;
                        end else begin
                            sda_low <= 1'b1;
                        end
                    end
                PH_HOLD:
                    if (last) begin
                        scl_low <= 1'b1;
                        done    <= 1'b1;
                    end
                default: ;
            endcase
        end
    end

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({upd_stb, smp_stb, done}));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (st == PH_IDLE) && ($past(st) != PH_IDLE));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PH_LOW || st == PH_HIGH || st == PH_SETUP || st == PH_HOLD) |-> (cnt < lim));

    // R3
    scl_release_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_low) |-> ($past(st) == PH_LOW));

    // R5
    scl_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_low) |-> ($past(st) == PH_HIGH || $past(st) == PH_HOLD));

    // R7
    stretch_rel_chk: assert property (@(posedge clk) disable iff (rst)
        stretch |-> !scl_low);

    // R11
    sda_under_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(scl_low) && !$stable(sda_low)) |->
            ($past(st) == PH_SETUP || $past(st) == PH_IDLE));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int CW = DEF_CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_dsetup,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic          cmd_bit,
    output logic          cmd_ready,
    input  logic          scl_in,
    output logic          scl_drive_low,
    output logic          sda_drive_low,
    output logic          sda_update_stb,
    output logic          sda_sample_stb,
    output logic          stretch_seen,
    output logic          done_stb
);
    logic [CW-1:0] lim_low, lim_high, pos_dset, lim_su_rise, lim_su_hold, pos_smp;
    logic [CW-1:0] cnt, lim;
    logic          last, cnt_clr;

    scl_limits #(.CW(CW)) u_lims (
        .cfg_period (cfg_period),
        .cfg_low    (cfg_low),
        .cfg_setup  (cfg_setup),
        .cfg_dsetup (cfg_dsetup),
        .lim_low    (lim_low),
        .lim_high   (lim_high),
        .pos_dset   (pos_dset),
        .lim_su_rise(lim_su_rise),
        .lim_su_hold(lim_su_hold),
        .pos_smp    (pos_smp)
    );

    scl_phase_cnt #(.CW(CW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .lim (lim),
        .cnt (cnt),
        .last(last)
    );

    scl_seq_fsm #(.CW(CW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_bit    (cmd_bit),
        .scl_in     (scl_in),
        .lim_low    (lim_low),
        .lim_high   (lim_high),
        .pos_dset   (pos_dset),
        .lim_su_rise(lim_su_rise),
        .lim_su_hold(lim_su_hold),
        .pos_smp    (pos_smp),
        .cnt        (cnt),
        .last       (last),
        .lim        (lim),
        .cnt_clr    (cnt_clr),
        .cmd_ready  (cmd_ready),
        .scl_low    (scl_drive_low),
        .sda_low    (sda_drive_low),
        .upd_stb    (sda_update_stb),
        .smp_stb    (sda_sample_stb),
        .stretch    (stretch_seen),
        .done       (done_stb)
    );
endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cfg_period = '0, cfg_low = '0, cfg_setup = '0, cfg_dsetup = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic          cmd_bit = 1'b0;
    logic          cmd_ready, scl_in, scl_drive_low, sda_drive_low;
    logic          sda_update_stb, sda_sample_stb, stretch_seen, done_stb;
    logic          hold = 1'b0;

    always #5 clk = ~clk;

    assign scl_in = !scl_drive_low && !hold;

    scl_timing_gen #(.CW(CW)) uut (
        .clk(clk), .rst(rst),
        .cfg_period(cfg_period), .cfg_low(cfg_low),
        .cfg_setup(cfg_setup), .cfg_dsetup(cfg_dsetup),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
        .cmd_ready(cmd_ready), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .sda_update_stb(sda_update_stb), .sda_sample_stb(sda_sample_stb),
        .stretch_seen(stretch_seen), .done_stb(done_stb)
    );

    int checks = 0, errors = 0, cyc = 0;
    int t_upd, t_smp, t_rel, t_fall, t_done, t_sdlo, t_sdhi;
    int n_upd, n_smp, n_str, sda_rel, sda_end, scl_end;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic b, input int k, input bit ign);
        logic ps, pd;
        int   relc;
        @(negedge clk);
        check("R10 ready before command", int'(cmd_ready), 1);
        ps = scl_drive_low;
        pd = sda_drive_low;
        cmd_valid = 1'b1; cmd_op = op; cmd_bit = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        t_upd = -1; t_smp = -1; t_rel = -1; t_fall = -1; t_done = -1;
        t_sdlo = -1; t_sdhi = -1; sda_rel = -1;
        n_upd = 0; n_smp = 0; n_str = 0; relc = 0;
        for (int idx = 0; idx < 3000; idx++) begin
            if (idx > 0) @(negedge clk);
            hold = 1'b0;
            if (!scl_drive_low && relc < k) begin
                hold = 1'b1;
                relc++;
            end
            if (ign && idx == 2) begin
                cmd_valid = 1'b1; cmd_op = 2'd3;
            end else begin
                cmd_valid = 1'b0;
            end
            #1;
            if (sda_update_stb) begin n_upd++; if (t_upd < 0) t_upd = idx; end
            if (sda_sample_stb) begin n_smp++; if (t_smp < 0) t_smp = idx; end
            if (stretch_seen) n_str++;
            if (ps && !scl_drive_low && t_rel < 0) begin
                t_rel = idx;
                sda_rel = int'(sda_drive_low);
            end
            if (!ps && scl_drive_low && t_fall < 0) t_fall = idx;
            if (!pd && sda_drive_low) t_sdlo = idx;
            if (pd && !sda_drive_low) t_sdhi = idx;
            ps = scl_drive_low;
            pd = sda_drive_low;
            if (done_stb) begin
                t_done = idx;
                sda_end = int'(sda_drive_low);
                scl_end = int'(scl_drive_low);
                check("R10 ready with done", int'(cmd_ready), 1);
                break;
            end
        end
        cmd_valid = 1'b0;
        hold = 1'b0;
        check("R10 done reached", int'(t_done >= 0), 1);
        @(negedge clk);
        check("R10 done single cycle", int'(done_stb), 0);
    endtask

    task automatic verify(input logic [1:0] op, input logic b, input int k,
                          input int p, input int l, input int d, input int s);
        int lo, hi, ds, sr, sh;
        lo = (l < 1) ? 1 : l;
        hi = (p - lo < 2) ? 2 : p - lo;
        ds = (d > lo - 1) ? lo - 1 : d;
        sr = (s < 2) ? 2 : s;
        sh = (s < 1) ? 1 : s;
        case (op)
            2'd0: begin
                check("R2 start sda low cycle", t_sdlo, 0);
                check("R2 start scl low cycle", t_fall, sh);
                check("R10 start done cycle", t_done, sh);
            end
            2'd1: begin
                check("R4 bit update cycle", t_upd, ds);
                check("R4 bit update count", n_upd, 1);
                check("R4 bit sda value", sda_end, int'(!b));
                check("R3 bit scl release", t_rel, lo);
                check("R6 sample cycle", t_smp, lo + k + hi / 2);
                check("R6 sample count", n_smp, 1);
                check("R5 bit scl fall", t_fall, lo + k + hi);
                check("R10 bit done cycle", t_done, lo + k + hi);
                check("R7 stretch cycles", n_str, k);
            end
            2'd2: begin
                check("R4 restart update cycle", t_upd, ds);
                check("R9 restart sda released at rise", sda_rel, 0);
                check("R3 restart scl release", t_rel, lo);
                check("R9 restart sda low", t_sdlo, lo + sr);
                check("R9 restart scl low", t_fall, lo + sr + sh);
                check("R10 restart done", t_done, lo + sr + sh);
            end
            default: begin
                check("R4 stop update cycle", t_upd, ds);
                check("R8 stop sda low at rise", sda_rel, 1);
                check("R3 stop scl release", t_rel, lo);
                check("R8 stop sda release", t_sdhi, lo + sr);
                check("R8 stop done", t_done, lo + sr);
                check("R8 stop scl stays released", scl_end, 0);
                check("R8 stop no scl fall", t_fall, -1);
            end
        endcase
    endtask

    task automatic sequence_run(input int p, input int l, input int d, input int s, input int k);
        cfg_period = CW'(p); cfg_low = CW'(l); cfg_dsetup = CW'(d); cfg_setup = CW'(s);
        run_cmd(2'd0, 1'b0, 0, 1'b0); verify(2'd0, 1'b0, 0, p, l, d, s);
        run_cmd(2'd1, 1'b1, 0, 1'b1); verify(2'd1, 1'b1, 0, p, l, d, s);
        run_cmd(2'd1, 1'b0, k, 1'b0); verify(2'd1, 1'b0, k, p, l, d, s);
        run_cmd(2'd2, 1'b0, 0, 1'b0); verify(2'd2, 1'b0, 0, p, l, d, s);
        run_cmd(2'd1, 1'b0, 0, 1'b0); verify(2'd1, 1'b0, 0, p, l, d, s);
        run_cmd(2'd3, 1'b0, 0, 1'b0); verify(2'd3, 1'b0, 0, p, l, d, s);
    endtask

    initial begin
        int periods[3] = '{5, 8, 11};
        int dsets[4]   = '{0, 1, 3, 7};
        int sus[4]     = '{0, 1, 2, 4};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset scl released", int'(scl_drive_low), 0);
        check("R1 reset sda released", int'(sda_drive_low), 0);
        check("R1 reset ready", int'(cmd_ready), 1);
        check("R1 reset strobes idle",
              int'({sda_update_stb, sda_sample_stb, stretch_seen, done_stb}), 0);

        foreach (periods[pi])
            for (int l = 0; l < 6; l++)
                foreach (dsets[di])
                    foreach (sus[si])
                        sequence_run(periods[pi], l, dsets[di], sus[si], (si % 2) * 3);

        // full-rate settings for a 100 MHz clock: 100 kHz and 400 kHz
        sequence_run(1000, 500, 62, 500, 7);
        sequence_run(250, 125, 15, 125, 0);

        finish_run();
    end
endmodule